// File: doc/BRIEF.md
# Real-Time Clock Access Window Controller

This block stands between a CPU register bus and a free-running time-of-day counter. The counter holds a subsecond count, seconds, minutes, hours and a 16-bit day number. Software cannot reach those fields at any moment. It must first open a read window or a write window through a control register. Opening either window holds the counter still, so software sees a stable time. Ticks that arrive while the counter is held are kept in a pending count. They are applied one per cycle after the window closes, so no time is lost.

Windows close when software clears the bit, or by themselves after a timeout. After any close, a short lockout refuses a new open. The write-window bit and the oscillator-enable bit are guarded by a two-byte unlock sequence. A system reset closes any window but keeps the time and the oscillator setting. A power-on reset clears everything.

The window controller is a four-state machine. Its states are IDLE (no window), READ (read window open, counter frozen), WRITE (write window open, counter frozen) and LOCK (re-arm lockout). Its transitions are:
- IDLE to READ on an accepted read open.
- IDLE to WRITE on an unlocked write open.
- READ or WRITE to LOCK on a software clear or on timeout.
- LOCK to IDLE after the lockout count.

The unlock unit is a three-state machine. Its states are KEY-IDLE, ARMED (first key seen) and OPEN (protected write allowed). Its transitions are:
- KEY-IDLE to ARMED on the first key.
- ARMED to OPEN on the second key in the very next cycle, and ARMED back to KEY-IDLE otherwise.
- OPEN to KEY-IDLE when the control register is written, or after three cycles.

Top module: `rtc_access_ctrl`

## Requirements
- R1: A control-register write whose data has both bit 2 (read window) and bit 1 (write window) set leaves both window bits unchanged, whether or not the unlock is open.
- R2: After a window bit clears, a write that would set either window bit is ignored for the next 4 cycles.
- R3: While the read window is open, the time fields do not change. Ticks received meanwhile are applied after the close.
- R4: Reads of the time fields (addresses 2 to 7) return 0xA5 unless the read window is open and inside its valid span. The valid span runs from window cycle 4 up to, but not including, WINDOW_CYCLES (default 1000).
- R5: A window that software leaves open is closed by hardware once it has been open TIMEOUT_CYCLES cycles (default 1950).
- R6: During the first 4 cycles after a window opens, time reads return 0xA5 and time writes are discarded.
- R7: Writes to time fields are discarded unless the write window is open and inside its valid span.
- R8: Bits 1 (write window) and 0 (oscillator enable) of the control register (address 0) change only on a control write that follows the unlock sequence. The unlock sequence is 0xAA then 0x55 written to address 1 on consecutive cycles. The control write must land in one of the 3 cycles after the second key.
- R9: Closing the write window clears the subsecond field to zero.
- R10: With the oscillator disabled, ticks are ignored and the time holds.
- R11: rst_n closes any window and keeps the oscillator bit and the time. por_n clears the control register and all time fields.
- R12: The time carries from subsecond (0 to 255, address 2) into seconds (0 to 59, address 3), minutes (0 to 59, address 4) and hours (0 to 23, address 5). Hours carry into a 16-bit day count, with its low byte at address 6 and its high byte at address 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine clock |
| rst_n | input | 1 | System reset, active low, asynchronous |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tick_in | input | 1 | One pulse per subsecond increment from the oscillator |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |

## Verification
The hardest situation to reach from the ports is a backlog of pending ticks that drains exactly once after a freeze. Ticks delivered during a read window must not appear in the time while the window is open, and must all appear after it closes. The stimulus opens a read window and waits out the synchronisation cycles. It reads the subsecond field, delivers a burst of ticks, and reads again to confirm nothing moved. It then closes the window, idles past the drain, and reads the time through a fresh window to find the exact tick total. The timeout and the valid-span edge are reached by holding a window open for a counted number of cycles and probing on the exact boundary cycles.

// File: rtl/rtc_access_pkg.sv
package rtc_access_pkg;

    typedef enum logic [1:0] {WS_IDLE, WS_READ, WS_WRITE, WS_LOCK} win_state_e;
    typedef enum logic [1:0] {TA_IDLE, TA_ARMED, TA_OPEN} ta_state_e;

    localparam logic [2:0] A_CTRL   = 3'd0;
    localparam logic [2:0] A_UNLOCK = 3'd1;
    localparam logic [2:0] A_SUB    = 3'd2;
    localparam logic [2:0] A_SEC    = 3'd3;
    localparam logic [2:0] A_MIN    = 3'd4;
    localparam logic [2:0] A_HOUR   = 3'd5;
    localparam logic [2:0] A_DAYLO  = 3'd6;
    localparam logic [2:0] A_DAYHI  = 3'd7;

    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;

    localparam int CB_OSC = 0;
    localparam int CB_WR  = 1;
    localparam int CB_RD  = 2;

    typedef struct packed {
        logic [15:0] day;
        logic [7:0]  hour;
        logic [7:0]  min;
        logic [7:0]  sec;
        logic [7:0]  sub;
    } rtc_time_t;

endpackage

// File: rtl/rtc_unlock.sv
module rtc_unlock
    import rtc_access_pkg::*;
#(
    parameter int OPEN_CYCLES = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr,
    input  logic [7:0] key_data,
    input  logic       consume,
    output logic       ta_ok
);
    localparam int CW = $clog2(OPEN_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LOAD = CW'(OPEN_CYCLES);

    ta_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TA_IDLE:  if (key_wr && key_data == KEY_FIRST) state_d = TA_ARMED;
            TA_ARMED: begin
                if (key_wr && key_data == KEY_SECOND)     state_d = TA_OPEN;
                else if (key_wr && key_data == KEY_FIRST) state_d = TA_ARMED;
                else                                      state_d = TA_IDLE;
            end
            TA_OPEN:  if (consume || cnt_q == CW'(1)) state_d = TA_IDLE;
            default:  state_d = TA_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TA_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != TA_OPEN && state_d == TA_OPEN) cnt_q <= CNT_LOAD;
            else if (state_q == TA_OPEN)                  cnt_q <= cnt_q - CW'(1);
        end
    end

    always_comb begin
        ta_ok = (state_q == TA_OPEN);
    end

endmodule

// File: rtl/rtc_window_fsm.sv
module rtc_window_fsm
    import rtc_access_pkg::*;
#(
    parameter int SYNC_CYCLES    = 4,
    parameter int WINDOW_CYCLES  = 1000,
    parameter int TIMEOUT_CYCLES = 1950,
    parameter int LOCKOUT_CYCLES = 4,
    localparam int CW = $clog2(TIMEOUT_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_wr,
    input  logic          req_rd,
    input  logic          req_wr,
    input  logic          ta_ok,
    output logic          rd_en,
    output logic          wr_en,
    output logic          rd_valid,
    output logic          wr_valid,
    output logic          wr_close,
    output logic [CW-1:0] win_cnt
);
    localparam logic [CW-1:0] TO_LAST = CW'(TIMEOUT_CYCLES - 1);
    localparam logic [CW-1:0] LK_LAST = CW'(LOCKOUT_CYCLES - 1);
    localparam logic [CW-1:0] SYNC_N  = CW'(SYNC_CYCLES);
    localparam logic [CW-1:0] SPAN_N  = CW'(WINDOW_CYCLES);

    win_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          both, timeout, in_span;

    always_comb begin
        both    = req_rd && req_wr;
        timeout = (cnt_q == TO_LAST);
        state_d = state_q;
        unique case (state_q)
            WS_IDLE: if (ctrl_wr && !both) begin
                if (req_rd)              state_d = WS_READ;
                else if (req_wr && ta_ok) state_d = WS_WRITE;
            end
            WS_READ:  if (timeout || (ctrl_wr && !both && !req_rd)) state_d = WS_LOCK;
            WS_WRITE: if (timeout || (ctrl_wr && ta_ok && !both && !req_wr)) state_d = WS_LOCK;
            WS_LOCK:  if (cnt_q == LK_LAST) state_d = WS_IDLE;
            default:  state_d = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q || state_d == WS_IDLE) cnt_q <= '0;
            else                                          cnt_q <= cnt_q + CW'(1);
        end
    end

    always_comb begin
        in_span  = (cnt_q >= SYNC_N) && (cnt_q < SPAN_N);
        rd_en    = (state_q == WS_READ);
        wr_en    = (state_q == WS_WRITE);
        rd_valid = rd_en && in_span;
        wr_valid = wr_en && in_span;
        wr_close = wr_en && (state_d == WS_LOCK);
        win_cnt  = cnt_q;
    end

endmodule

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
    import rtc_access_pkg::*;
#(
    parameter int SUBSEC_TICKS = 256,
    parameter int PEND_W       = 11
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       tick,
    input  logic       osc_en,
    input  logic       freeze,
    input  logic       load_en,
    input  logic [2:0] load_sel,
    input  logic [7:0] load_data,
    input  logic       clr_sub,
    output rtc_time_t  time_o
);
    localparam logic [7:0]        SUB_LAST  = 8'(SUBSEC_TICKS - 1);
    localparam logic [PEND_W-1:0] PEND_FULL = '1;

    rtc_time_t         t_q;
    logic [PEND_W-1:0] pend_q, pend_d;
    logic              tick_v, advance;

    function automatic rtc_time_t step(input rtc_time_t t);
        rtc_time_t n = t;
        if (t.sub != SUB_LAST) n.sub = t.sub + 8'd1;
        else begin
            n.sub = '0;
            if (t.sec != 8'd59) n.sec = t.sec + 8'd1;
            else begin
                n.sec = '0;
                if (t.min != 8'd59) n.min = t.min + 8'd1;
                else begin
                    n.min = '0;
                    if (t.hour != 8'd23) n.hour = t.hour + 8'd1;
                    else begin
                        n.hour = '0;
                        n.day  = t.day + 16'd1;
                    end
                end
            end
        end
        return n;
    endfunction

    always_comb begin
        tick_v  = tick && osc_en;
        advance = osc_en && !freeze && (tick_v || pend_q != '0);
        pend_d  = pend_q;
        if (tick_v && !advance && pend_q != PEND_FULL) pend_d = pend_q + PEND_W'(1);
        else if (!tick_v && advance)                   pend_d = pend_q - PEND_W'(1);
        time_o = t_q;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            t_q    <= '0;
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
            if (load_en) begin
                case (load_sel)
                    A_SUB:   t_q.sub       <= load_data;
                    A_SEC:   t_q.sec       <= load_data;
                    A_MIN:   t_q.min       <= load_data;
                    A_HOUR:  t_q.hour      <= load_data;
                    A_DAYLO: t_q.day[7:0]  <= load_data;
                    A_DAYHI: t_q.day[15:8] <= load_data;
                    default: ;
                endcase
            end else if (clr_sub) begin
                t_q.sub <= '0;
            end else if (advance) begin
                t_q <= step(t_q);
            end
        end
    end

endmodule

// File: rtl/rtc_access_ctrl.sv
module rtc_access_ctrl
    import rtc_access_pkg::*;
#(
    parameter int SYNC_CYCLES    = 4,
    parameter int WINDOW_CYCLES  = 1000,
    parameter int TIMEOUT_CYCLES = 1950,
    parameter int LOCKOUT_CYCLES = 4,
    parameter int UNLOCK_CYCLES  = 3,
    parameter int SUBSEC_TICKS   = 256,
    parameter logic [7:0] GARBAGE = 8'hA5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       por_n,
    input  logic       tick_in,
    input  logic       bus_wr,
    input  logic [2:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata
);
    localparam int WIN_W  = $clog2(TIMEOUT_CYCLES + 1);
    localparam int PEND_W = $clog2(TIMEOUT_CYCLES + 2);

    logic             ctrl_wr, key_wr, ta_ok;
    logic             rd_en, wr_en, rd_valid, wr_valid, wr_close;
    logic             osc_en, time_ld;
    logic [WIN_W-1:0] win_cnt;
    rtc_time_t        cur_time;

    always_comb begin
        ctrl_wr = bus_wr && bus_addr == A_CTRL;
        key_wr  = bus_wr && bus_addr == A_UNLOCK;
        time_ld = bus_wr && wr_valid && bus_addr >= A_SUB;
    end

    rtc_unlock #(.OPEN_CYCLES(UNLOCK_CYCLES)) unlock_i (
        .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_data(bus_wdata),
        .consume(ctrl_wr), .ta_ok(ta_ok)
    );

    rtc_window_fsm #(
        .SYNC_CYCLES(SYNC_CYCLES), .WINDOW_CYCLES(WINDOW_CYCLES),
        .TIMEOUT_CYCLES(TIMEOUT_CYCLES), .LOCKOUT_CYCLES(LOCKOUT_CYCLES)
    ) window_i (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr),
        .req_rd(bus_wdata[CB_RD]), .req_wr(bus_wdata[CB_WR]), .ta_ok(ta_ok),
        .rd_en(rd_en), .wr_en(wr_en), .rd_valid(rd_valid), .wr_valid(wr_valid),
        .wr_close(wr_close), .win_cnt(win_cnt)
    );

    rtc_time_counter #(.SUBSEC_TICKS(SUBSEC_TICKS), .PEND_W(PEND_W)) counter_i (
        .clk(clk), .por_n(por_n), .tick(tick_in), .osc_en(osc_en),
        .freeze(rd_en || wr_en), .load_en(time_ld), .load_sel(bus_addr),
        .load_data(bus_wdata), .clr_sub(wr_close), .time_o(cur_time)
    );

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                 osc_en <= 1'b0;
        else if (ctrl_wr && ta_ok)  osc_en <= bus_wdata[CB_OSC];
    end

    always_comb begin
        bus_rdata = GARBAGE;
        case (bus_addr)
            A_CTRL:   bus_rdata = {5'b0, rd_en, wr_en, osc_en};
            A_UNLOCK: bus_rdata = 8'h00;
            A_SUB:    if (rd_valid) bus_rdata = cur_time.sub;
            A_SEC:    if (rd_valid) bus_rdata = cur_time.sec;
            A_MIN:    if (rd_valid) bus_rdata = cur_time.min;
            A_HOUR:   if (rd_valid) bus_rdata = cur_time.hour;
            A_DAYLO:  if (rd_valid) bus_rdata = cur_time.day[7:0];
            default:  if (rd_valid) bus_rdata = cur_time.day[15:8];
        endcase
    end

endmodule

// File: rtl/rtc_access_ctrl_chk.sv
module rtc_access_ctrl_chk #(
    parameter int TIMEOUT_CYCLES = 1950,
    parameter int CNT_W = 11,
    parameter logic [7:0] GARBAGE = 8'hA5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             por_n,
    input logic             rd_en,
    input logic             wr_en,
    input logic             osc_en,
    input logic             ta_ok,
    input logic [CNT_W-1:0] win_cnt,
    input logic [47:0]      time_flat,
    input logic [2:0]       bus_addr,
    input logic [7:0]       bus_rdata
);
    logic win_any;
    always_comb win_any = rd_en || wr_en;

    assert_lockout_hold_R2: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        $fell(win_any) |-> !win_any ##1 !win_any ##1 !win_any ##1 !win_any);

    assert_freeze_stable_R3: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        rd_en |=> $stable(time_flat));

    assert_gated_read_R4: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (bus_addr >= 3'd2 && !rd_en) |-> bus_rdata == GARBAGE);

    assert_window_bound_R5: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        win_any |-> win_cnt < CNT_W'(TIMEOUT_CYCLES));

    assert_wr_unlocked_R8: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        $rose(wr_en) |-> $past(ta_ok));

    assert_osc_unlocked_R8: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        ($rose(osc_en) || $fell(osc_en)) |-> $past(ta_ok));

    assert_osc_halt_R10: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (!osc_en && !wr_en) |=> $stable(time_flat));

endmodule

bind rtc_access_ctrl rtc_access_ctrl_chk #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES), .CNT_W(WIN_W), .GARBAGE(GARBAGE)
) chk_i (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .rd_en(rd_en), .wr_en(wr_en),
    .osc_en(osc_en), .ta_ok(ta_ok), .win_cnt(win_cnt), .time_flat(cur_time),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/rtc_access_ctrl_tb_top.sv
module rtc_access_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WINDOW_N   = 1000;
    localparam int TIMEOUT_N  = 1950;
    localparam logic [2:0] AC = 3'd0, AU = 3'd1, AS = 3'd2, ASEC = 3'd3,
                           AMIN = 3'd4, AHR = 3'd5, ADL = 3'd6, ADH = 3'd7;
    localparam logic [7:0] JUNK = 8'hA5;

    logic       clk = 1'b0, rst_n = 1'b0, por_n = 1'b0, tick_in = 1'b0, bus_wr = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    int total = 0, bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_access_ctrl #(.WINDOW_CYCLES(WINDOW_N), .TIMEOUT_CYCLES(TIMEOUT_N)) dut_i (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .tick_in(tick_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic peek(input string tag, input logic [2:0] a, input logic [7:0] exp);
        bus_addr = a; #1;
        chk(tag, $sformatf("addr %0d", a), bus_rdata, exp);
    endtask

    task automatic unlock();
        wr(AU, 8'hAA); wr(AU, 8'h55);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_in = 1'b1; @(posedge clk); @(negedge clk); tick_in = 1'b0;
        end
    endtask

    task automatic expect_time(input string tag, input logic [7:0] s, sec, mn, hr, input logic [15:0] day);
        idle(6); wr(AC, 8'h04); idle(4);
        peek(tag, AS, s); peek(tag, ASEC, sec); peek(tag, AMIN, mn);
        peek(tag, AHR, hr); peek(tag, ADL, day[7:0]); peek(tag, ADH, day[15:8]);
        wr(AC, 8'h00);
    endtask

    task automatic t_reset();
        idle(3); por_n = 1'b1; rst_n = 1'b1; idle(1);
        peek("R11", AC, 8'h00);
        peek("R4", AS, JUNK);
    endtask

    task automatic t_unlock();
        unlock(); wr(AC, 8'h01); peek("R8", AC, 8'h01);
        wr(AC, 8'h00); peek("R8", AC, 8'h01);
        wr(AU, 8'hAA); idle(1); wr(AU, 8'h55); wr(AC, 8'h00); peek("R8", AC, 8'h01);
        unlock(); idle(3); wr(AC, 8'h00); peek("R8", AC, 8'h01);
    endtask

    task automatic t_both();
        idle(6); wr(AC, 8'h06); peek("R1", AC, 8'h01);
        unlock(); wr(AC, 8'h07); peek("R1", AC, 8'h01);
    endtask

    task automatic t_set_time();
        idle(6); wr(ADH, 8'h33);
        unlock(); wr(AC, 8'h03); peek("R8", AC, 8'h03);
        wr(ADH, 8'h44); idle(3);
        wr(AS, 8'h80); wr(ASEC, 8'd59); wr(AMIN, 8'd59); wr(AHR, 8'd23); wr(ADL, 8'hFF);
        peek("R4", ASEC, JUNK);
        unlock(); wr(AC, 8'h01); peek("R9", AC, 8'h01);
        expect_time("R6 R7 R9", 8'h00, 8'd59, 8'd59, 8'd23, 16'h00FF);
    endtask

    task automatic t_rollover();
        ticks(256); idle(3);
        expect_time("R12", 8'h00, 8'd0, 8'd0, 8'd0, 16'h0100);
    endtask

    task automatic t_freeze();
        idle(6); wr(AC, 8'h04); idle(4);
        peek("R3", AS, 8'h00);
        ticks(10);
        peek("R3", AS, 8'h00); peek("R3", ASEC, 8'h00);
        wr(AC, 8'h00); idle(15);
        expect_time("R3", 8'h0A, 8'd0, 8'd0, 8'd0, 16'h0100);
    endtask

    task automatic t_lockout();
        idle(6); wr(AC, 8'h04); wr(AC, 8'h00); wr(AC, 8'h04);
        peek("R2", AC, 8'h01);
        idle(5); wr(AC, 8'h04); peek("R2", AC, 8'h05);
        wr(AC, 8'h00);
    endtask

    task automatic t_timeout();
        idle(6); wr(AC, 8'h04);
        peek("R6", AS, JUNK);
        idle(4); peek("R4", AS, 8'h0A);
        idle(WINDOW_N - 4); peek("R4", AS, JUNK);
        idle(TIMEOUT_N - 1 - WINDOW_N); peek("R5", AC, 8'h05);
        idle(1); peek("R5", AC, 8'h01);
    endtask

    task automatic t_osc_off();
        idle(6); unlock(); wr(AC, 8'h00); peek("R10", AC, 8'h00);
        ticks(5); idle(2);
        expect_time("R10", 8'h0A, 8'd0, 8'd0, 8'd0, 16'h0100);
        idle(6); unlock(); wr(AC, 8'h01);
    endtask

    task automatic t_resets();
        idle(6); wr(AC, 8'h04); idle(1);
        rst_n = 1'b0; idle(1); rst_n = 1'b1;
        peek("R11", AC, 8'h01);
        expect_time("R11", 8'h0A, 8'd0, 8'd0, 8'd0, 16'h0100);
        por_n = 1'b0; rst_n = 1'b0; idle(2); por_n = 1'b1; rst_n = 1'b1;
        peek("R11", AC, 8'h00);
        expect_time("R11", 8'h00, 8'd0, 8'd0, 8'd0, 16'h0000);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_unlock();
        t_both();
        t_set_time();
        t_rollover();
        t_freeze();
        t_lockout();
        t_timeout();
        t_osc_off();
        t_resets();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule